// File: doc/BRIEF.md
# Two-Master Bus Lock Arbiter

This block decides which of two host masters may drive a shared downstream two-wire bus. Each master has its own control byte and its own reservation byte, both written through a dedicated per-side write port. A master asks for the bus by setting its request bit. It owns the bus while that bit stays set. It gives the bus up by clearing the bit. The per-side switch enable reaches the analog switch only when that side owns the bus and has also set its connect bit.

After a grant, a reservation timer counts down in milliseconds. When the reservation has run out, an optional idle watchdog can take the bus away from a holder that leaves the downstream bus quiet for more than a set number of milliseconds. Both timers advance on a one-cycle millisecond tick input, so the surrounding logic sets their time base. Each side gets a one-cycle pulse when it receives a grant. It gets a different one-cycle pulse when its grant is taken away without its consent.

Top module: `bus_lock_arbiter`

## Requirements
- R1: After synchronous reset, no side is granted, every switch enable is low and no event pulse is raised.
- R2: A request bit (control bit 0) written while the bus is free is granted at the next clock edge. In the cycle the grant first shows, `lock_grant_evt` for that side pulses high for exactly one cycle.
- R3: When both sides request the free bus in the same cycle, the side whose priority bit (control bit 7) is set alone wins. If neither or both priority bits are set, side 0 wins.
- R4: Grants are mutually exclusive. A request from the other side while the bus is held stays pending and is granted on the edge after the holder releases or loses the bus.
- R5: Writing control bit 0 to zero drops that side's grant on the same edge as the write and raises no bus-lost pulse.
- R6: `sw_en[i]` is high exactly when side i is granted and its connect bit (control bit 2) is set.
- R7: `other_lock[i]` reflects the grant held by the opposite side.
- R8: A write to the reservation byte (`wr_addr` = 1; `wr_addr` = 0 selects the control byte) is ignored while the writing side holds the grant. The reservation value is loaded into the countdown at grant time.
- R9: With the idle-disconnect bit (control bit 5) set, the holder loses the bus under these conditions: the reservation count has reached zero, and then 101 consecutive ticks arrive with `bus_active` low. The grant is revoked on the edge after the 101st such tick, its request bit is cleared, and `bus_lost_evt` pulses for one cycle. With a reservation of 3 and a tick every cycle, the revocation falls 105 cycles after the grant first shows.
- R10: Downstream activity restarts the idle count. With the idle-disconnect bit clear, a holder is never revoked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 2 | Per-side write strobe |
| wr_addr | input | 2 | Per-side register select: 0 control byte, 1 reservation byte |
| wr_data | input | 16 | Per-side write data, side i in bits [8i+7:8i] |
| ms_tick | input | 1 | One-cycle millisecond tick |
| bus_active | input | 1 | High while the downstream bus shows traffic |
| grant | output | 2 | Per-side lock grant |
| other_lock | output | 2 | Opposite side's grant, per side |
| sw_en | output | 2 | Per-side switch enable |
| lock_grant_evt | output | 2 | One-cycle pulse on receiving the grant |
| bus_lost_evt | output | 2 | One-cycle pulse on involuntary loss of the grant |

## Verification
The bench targets the same-cycle request from both sides under all four priority combinations. A design that tied the wrong way, or granted both sides at once, would show two grant bits or the wrong winner. It times the idle revocation to the exact cycle and runs it again after an attempted reservation rewrite during a hold. An off-by-one in the "more than" compare, a tick counted on the expiring reservation cycle, or a write that slipped past the lock would each move the revocation off cycle 105. It also checks that a voluntary release opens the switch on the write edge with no bus-lost pulse, and that a revoked side does not win the bus back through a request bit left set.

// File: rtl/bla_pkg.sv
package bla_pkg;

    localparam int NUM_SIDES = 2;

    // Control byte field positions (decoded by the register slice)
    localparam int CB_REQ  = 0;
    localparam int CB_CONN = 2;
    localparam int CB_IDLE = 5;
    localparam int CB_PRIO = 7;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_M0   = 2'd1,
        OWN_M1   = 2'd2
    } owner_e;

    typedef struct packed {
        logic prio;
        logic idle_en;
        logic connect;
        logic req;
    } side_ctrl_t;

    function automatic owner_e side_owner(input int s);
        return (s == 0) ? OWN_M0 : OWN_M1;
    endfunction

    // Tie-break: side 1 only when its priority bit alone is set
    function automatic owner_e pick_winner(input logic r0, input logic r1,
                                           input logic p0, input logic p1);
        if (r0 && r1) return (p1 && !p0) ? OWN_M1 : OWN_M0;
        if (r0)       return OWN_M0;
        if (r1)       return OWN_M1;
        return OWN_NONE;
    endfunction

endpackage

// File: rtl/bla_side_regs.sv
module bla_side_regs
    import bla_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RES_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hold,
    input  logic              hw_clr_req,
    output side_ctrl_t        ctrl,
    output logic [RES_W-1:0]  res_time
);

    logic unused_bits;
    assign unused_bits = ^{wr_data[6], wr_data[4:3], wr_data[1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            res_time <= '0;
        end else begin
            if (wr_en && !wr_addr) begin
                ctrl.req     <= wr_data[CB_REQ];
                ctrl.connect <= wr_data[CB_CONN];
                ctrl.idle_en <= wr_data[CB_IDLE];
                ctrl.prio    <= wr_data[CB_PRIO];
            end else if (hw_clr_req) begin
                ctrl.req <= 1'b0;
            end
            if (wr_en && wr_addr && !hold)
                res_time <= wr_data[RES_W-1:0];
        end
    end

    // R8
    res_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr && hold) |=> $stable(res_time));

endmodule

// File: rtl/bla_side_timer.sv
module bla_side_timer #(
    parameter int RES_W   = 8,
    parameter int IDLE_MS = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             held,
    input  logic [RES_W-1:0] load_val,
    input  logic             tick,
    input  logic             bus_active,
    input  logic             idle_en,
    output logic             revoke
);

    localparam int IDLE_W   = $clog2(IDLE_MS + 2);
    localparam int IDLE_SAT = IDLE_MS + 1;

    logic [RES_W-1:0]  res_cnt;
    logic [IDLE_W-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_cnt  <= '0;
            idle_cnt <= '0;
        end else if (start) begin
            res_cnt  <= load_val;
            idle_cnt <= '0;
        end else if (!held) begin
            res_cnt  <= '0;
            idle_cnt <= '0;
        end else begin
            if (tick && res_cnt != '0)
                res_cnt <= res_cnt - 1'b1;
            if (bus_active)
                idle_cnt <= '0;
            else if (tick && res_cnt == '0 && idle_cnt != IDLE_W'(IDLE_SAT))
                idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign revoke = held && idle_en && (res_cnt == '0) &&
                    (idle_cnt > IDLE_W'(IDLE_MS));

    // R9
    res_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (held && !start && !tick) |=> $stable(res_cnt));

endmodule

// File: rtl/bus_lock_arbiter.sv
module bus_lock_arbiter
    import bla_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int RES_W   = 8,
    parameter int IDLE_MS = 100
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_SIDES-1:0]            wr_en,
    input  logic [NUM_SIDES-1:0]            wr_addr,
    input  logic [NUM_SIDES*DATA_W-1:0]     wr_data,
    input  logic                            ms_tick,
    input  logic                            bus_active,
    output logic [NUM_SIDES-1:0]            grant,
    output logic [NUM_SIDES-1:0]            other_lock,
    output logic [NUM_SIDES-1:0]            sw_en,
    output logic [NUM_SIDES-1:0]            lock_grant_evt,
    output logic [NUM_SIDES-1:0]            bus_lost_evt
);

    owner_e                 owner_q, owner_d;
    side_ctrl_t             ctrl_q [NUM_SIDES];
    logic [RES_W-1:0]       res_time [NUM_SIDES];
    logic [NUM_SIDES-1:0]   req_v, prio_v, revoke, start, held;

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        bla_side_regs #(.DATA_W(DATA_W), .RES_W(RES_W)) u_regs (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (wr_en[g]),
            .wr_addr    (wr_addr[g]),
            .wr_data    (wr_data[g*DATA_W +: DATA_W]),
            .hold       (grant[g]),
            .hw_clr_req (revoke[g]),
            .ctrl       (ctrl_q[g]),
            .res_time   (res_time[g])
        );

        bla_side_timer #(.RES_W(RES_W), .IDLE_MS(IDLE_MS)) u_timer (
            .clk        (clk),
            .rst        (rst),
            .start      (start[g]),
            .held       (held[g]),
            .load_val   (res_time[g]),
            .tick       (ms_tick),
            .bus_active (bus_active),
            .idle_en    (ctrl_q[g].idle_en),
            .revoke     (revoke[g])
        );

        assign req_v[g]      = ctrl_q[g].req;
        assign prio_v[g]     = ctrl_q[g].prio;
        assign held[g]       = (owner_q == side_owner(g));
        assign grant[g]      = held[g] && req_v[g];
        assign sw_en[g]      = grant[g] && ctrl_q[g].connect;
        assign other_lock[g] = grant[NUM_SIDES-1-g];
        assign start[g]      = (owner_d == side_owner(g)) && !held[g];
    end

    // Holder keeps the bus while it requests and is not revoked;
    // otherwise arbitrate among the remaining requests this edge.
    logic keep;
    always_comb begin
        keep = (held[0] && req_v[0] && !revoke[0]) ||
               (held[1] && req_v[1] && !revoke[1]);
        owner_d = keep ? owner_q
                       : pick_winner(req_v[0] && !revoke[0], req_v[1] && !revoke[1],
                                     prio_v[0], prio_v[1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q        <= OWN_NONE;
            lock_grant_evt <= '0;
            bus_lost_evt   <= '0;
        end else begin
            owner_q        <= owner_d;
            lock_grant_evt <= start;
            bus_lost_evt   <= revoke;
        end
    end

    // R4
    excl_grant_chk: assert property (@(posedge clk) disable iff (rst)
        !(grant[0] && grant[1]));

    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (held[0] && req_v[0] && !revoke[0]) |=> held[0]);

    // R9
    lost_nogrant_chk: assert property (@(posedge clk) disable iff (rst)
        bus_lost_evt[0] |-> !grant[0]);

    // R9
    lost_nogrant1_chk: assert property (@(posedge clk) disable iff (rst)
        bus_lost_evt[1] |-> !grant[1]);

endmodule

// File: tb/bus_lock_arbiter_bench.sv
module bus_lock_arbiter_bench;

    localparam int IDLE_MS = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  wr_en = '0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ms_tick = 1'b0;
    logic        bus_active = 1'b0;
    logic [1:0]  grant, other_lock, sw_en, lock_grant_evt, bus_lost_evt;

    always #4 clk = ~clk;

    bus_lock_arbiter u_bus_lock_arbiter (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ms_tick(ms_tick), .bus_active(bus_active), .grant(grant),
        .other_lock(other_lock), .sw_en(sw_en), .lock_grant_evt(lock_grant_evt),
        .bus_lost_evt(bus_lost_evt)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string phase    = "R1";
    int    cycles   = 0;

    // Behavioural reference
    bit [1:0] m_req, m_conn, m_idle, m_prio, m_gevt, m_levt;
    int       m_rt [2];
    int       m_owner, m_res, m_idle_cnt;
    int       o, no;
    bit       rv, keep, r0, r1;
    bit [1:0] g_now;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_req = 0; m_conn = 0; m_idle = 0; m_prio = 0;
            m_rt[0] = 0; m_rt[1] = 0; m_owner = -1; m_res = 0; m_idle_cnt = 0;
            m_gevt = 0; m_levt = 0;
        end else begin
            o = m_owner;
            rv = (o >= 0) && m_idle[o] && m_res == 0 && m_idle_cnt > IDLE_MS;
            for (int s = 0; s < 2; s++) g_now[s] = (o == s) && m_req[s];
            keep = (o >= 0) && m_req[o] && !rv;
            r0 = m_req[0] && !(rv && o == 0);
            r1 = m_req[1] && !(rv && o == 1);
            if (keep) no = o;
            else if (r0 && r1) no = (m_prio[1] && !m_prio[0]) ? 1 : 0;
            else if (r0) no = 0;
            else if (r1) no = 1;
            else no = -1;
            for (int s = 0; s < 2; s++) begin
                m_gevt[s] = (no == s) && (o != s);
                m_levt[s] = rv && (o == s);
            end
            if (no >= 0 && no != o) begin
                m_res = m_rt[no]; m_idle_cnt = 0;
            end else if (no < 0) begin
                m_res = 0; m_idle_cnt = 0;
            end else begin
                if (bus_active) m_idle_cnt = 0;
                else if (ms_tick && m_res == 0 && m_idle_cnt <= IDLE_MS) m_idle_cnt++;
                if (ms_tick && m_res > 0) m_res--;
            end
            for (int s = 0; s < 2; s++) begin
                if (wr_en[s] && !wr_addr[s]) begin
                    m_req[s]  = wr_data[8*s+0];
                    m_conn[s] = wr_data[8*s+2];
                    m_idle[s] = wr_data[8*s+5];
                    m_prio[s] = wr_data[8*s+7];
                end else if (rv && o == s) m_req[s] = 0;
                if (wr_en[s] && wr_addr[s] && !g_now[s]) m_rt[s] = int'(wr_data[8*s +: 8]);
            end
            m_owner = no;
        end
    end

    function automatic bit [9:0] model_out();
        bit [1:0] g;
        for (int s = 0; s < 2; s++) g[s] = (m_owner == s) && m_req[s];
        return {g, {g[0], g[1]}, g & m_conn, m_gevt, m_levt};
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            n_checks++;
            if ({grant, other_lock, sw_en, lock_grant_evt, bus_lost_evt} !== model_out()) begin
                n_fail++;
                $display("FAIL %s cycle %0d: actual %b expected %b", phase, cycles,
                         {grant, other_lock, sw_en, lock_grant_evt, bus_lost_evt}, model_out());
            end
        end
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int s, input bit a, input bit [7:0] d);
        wr_en[s] = 1'b1; wr_addr[s] = a; wr_data[8*s +: 8] = d;
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic wr_both(input bit [7:0] d0, input bit [7:0] d1);
        wr_en = 2'b11; wr_addr = 2'b00; wr_data = {d1, d0};
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Cycles from first visible grant of side 0 to its bus-lost pulse
    task automatic measure_revoke(output int n);
        n = 0;
        while (!grant[0] && n < 10) begin @(negedge clk); n++; end
        n = 0;
        while (!bus_lost_evt[0] && n < 400) begin @(negedge clk); n++; end
    endtask

    int n;

    initial begin
        idle_cycles(3);
        rst = 1'b0;
        chk("R1 grant", grant, 0);
        chk("R1 sw_en", sw_en, 0);
        chk("R1 events", {lock_grant_evt, bus_lost_evt}, 0);

        phase = "R2";
        wr(0, 0, 8'h05);
        @(negedge clk);
        chk("R2 grant", grant, 1);
        chk("R2 grant event", lock_grant_evt, 1);
        chk("R6 switch on", sw_en, 1);
        chk("R7 other lock", other_lock, 2);

        phase = "R4";
        wr(1, 0, 8'h01);
        idle_cycles(3);
        chk("R4 pending", grant, 1);
        phase = "R5";
        wr(0, 0, 8'h04);
        chk("R5 release same edge", grant, 0);
        chk("R5 no bus lost", bus_lost_evt, 0);
        @(negedge clk);
        chk("R4 pending granted", grant, 2);
        chk("R6 no connect", sw_en, 0);
        wr(1, 0, 8'h00);
        idle_cycles(2);

        phase = "R3";
        wr_both(8'h01, 8'h01); @(negedge clk);
        chk("R3 no prio", grant, 1);
        wr_both(8'h00, 8'h00); idle_cycles(2);
        wr_both(8'h01, 8'h81); @(negedge clk);
        chk("R3 side1 prio", grant, 2);
        wr_both(8'h00, 8'h00); idle_cycles(2);
        wr_both(8'h81, 8'h81); @(negedge clk);
        chk("R3 both prio", grant, 1);
        wr_both(8'h00, 8'h00); idle_cycles(2);
        wr_both(8'h81, 8'h01); @(negedge clk);
        chk("R3 side0 prio", grant, 1);
        wr_both(8'h00, 8'h00); idle_cycles(2);

        phase = "R9";
        ms_tick = 1'b1;
        wr(0, 1, 8'd3);
        wr(0, 0, 8'h25);
        measure_revoke(n);
        chk("R9 revoke cycle", n, 105);
        chk("R9 grant dropped", grant, 0);
        idle_cycles(3);
        chk("R9 request cleared", grant, 0);

        phase = "R8";
        wr(0, 0, 8'h21);
        @(negedge clk);
        wr(0, 1, 8'd50);
        wr(0, 0, 8'h20);
        idle_cycles(2);
        wr(0, 0, 8'h21);
        measure_revoke(n);
        chk("R8 write while held ignored", n, 105);

        phase = "R10";
        wr(0, 0, 8'h21);
        idle_cycles(60);
        bus_active = 1'b1; @(negedge clk); bus_active = 1'b0;
        idle_cycles(60);
        chk("R10 activity restarts idle", grant, 1);
        idle_cycles(60);
        chk("R10 revoked later", grant, 0);
        wr(0, 0, 8'h01);
        idle_cycles(300);
        chk("R10 idle disabled keeps grant", grant, 1);
        wr(1, 0, 8'h05);
        idle_cycles(5);
        chk("R7 side1 sees lock", other_lock, 2);
        wr(0, 0, 8'h00);
        @(negedge clk);
        chk("R6 side1 switch", sw_en, 2);
        ms_tick = 1'b0;
        idle_cycles(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule